// File: doc/BRIEF.md
# Serial Byte to Pixel Assembler

This block sits between a byte receiver and a frame buffer. Each incoming byte comes with a one-cycle valid strobe. The block groups the bytes three at a time into one pixel. The first byte of a group is red, the second is green and the third is blue. Only the top four bits of each byte are kept, which gives a 12-bit RGB444 word. The finished word is written to the frame buffer through a one-cycle write strobe. The address starts at zero and counts up by one for each pixel.

A mode switch picks between two modes. In receive mode (switch low) bytes are accepted. In display mode (switch high) every byte is ignored and nothing is written. When the switch goes from high back to low, the block starts a new frame: the byte phase goes back to red and the address goes back to zero. After the configured number of pixels (by default 320x240 = 76800), the block stops writing and raises a frame-complete flag. That flag stays high until the next restart.

The controller has five named states:
- `ST_RED`, `ST_GREEN` and `ST_BLUE` wait for the byte of each colour.
- `ST_FULL` ignores bytes once the frame is complete.
- `ST_SHOW` is display mode.

Its transitions are:
- switch high → `ST_SHOW`, from any state.
- `ST_SHOW` with switch low → `ST_RED`, which is the restart.
- `ST_RED` → `ST_GREEN` on a valid byte.
- `ST_GREEN` → `ST_BLUE` on a valid byte.
- `ST_BLUE` → `ST_RED` on a valid byte that is not the last pixel.
- `ST_BLUE` → `ST_FULL` on a valid byte that completes the last pixel.
- Any receive state with no valid byte stays where it is.

Top module: `pixel_packer`

## Requirements
- R1: The accepted bytes of one pixel are taken in the order red, green, blue. The first accepted byte after reset or a restart is red.
- R2: `wr_data` is {red[7:4], green[7:4], blue[7:4]}. Red is in bits 11:8, green in bits 7:4 and blue in bits 3:0. The low nibble of every byte is dropped.
- R3: `wr_en` goes high for exactly one clock. It is high in the cycle after the clock edge that samples the blue byte.
- R4: The first pixel of a frame is written at `wr_addr` 0. Each later pixel is written at the previous address plus one. `wr_addr` keeps its last value while `wr_en` is low.
- R5: After `FRAME_PIXELS` pixels have been written (the last one at address `FRAME_PIXELS`-1), no further writes occur. `frame_done` rises in the same cycle as the final write.
- R6: While `disp_sw` is high, valid bytes are ignored and no write occurs. A byte sampled in the same cycle that the switch is high is also dropped.
- R7: On the first cycle with `disp_sw` low after it was high, the block restarts. The phase returns to red, the address returns to 0 and `frame_done` clears. A byte sampled in that restart cycle is dropped.
- R8: `frame_done` stays high through display mode until the next restart.
- R9: After reset, `wr_en`, `wr_addr`, `wr_data` and `frame_done` are 0, and the phase is red.
- R10: Cycles with `byte_vld` low do not advance the byte phase or the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | Byte strobe, one cycle per received byte |
| byte_dat | input | 8 | Received byte |
| disp_sw | input | 1 | Mode switch: 0 = receive, 1 = display |
| wr_en | output | 1 | Frame-buffer write strobe |
| wr_addr | output | 17 | Frame-buffer write address |
| wr_data | output | 12 | Packed RGB444 pixel |
| frame_done | output | 1 | Whole frame stored |

## Verification
The tests use the following byte patterns:
- Back-to-back bytes with distinct high and low nibbles show whether the colour order is right and whether the low nibbles are dropped.
- Bytes separated by idle gaps show that only valid strobes advance the phase.
- A pixel cut off partway by the display switch, with bytes sent while in display mode, shows that the restart returns the phase to red and the address to zero.
- A complete frame followed by surplus bytes shows where the final write lands and that writing stops after it.
- Holding display mode after the frame is complete shows that the completion flag stays set until the restart.

// File: rtl/pxpk_pkg.sv
package pxpk_pkg;

    typedef enum logic [2:0] {
        ST_RED   = 3'd0,
        ST_GREEN = 3'd1,
        ST_BLUE  = 3'd2,
        ST_FULL  = 3'd3,
        ST_SHOW  = 3'd4
    } pk_state_t;

endpackage

// File: rtl/pxpk_ctrl.sv
module pxpk_ctrl
    import pxpk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      byte_vld,
    input  logic      disp_sw,
    input  logic      last_pix,
    output pk_state_t state,
    output logic      take_red,
    output logic      take_green,
    output logic      commit,
    output logic      restart
);

    pk_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RED;
        else        state <= nxt;
    end

    always_comb begin
        nxt        = state;
        take_red   = 1'b0;
        take_green = 1'b0;
        commit     = 1'b0;
        restart    = 1'b0;
        if (disp_sw) begin
            nxt = ST_SHOW;
        end else begin
            unique case (state)
                ST_SHOW: begin
                    restart = 1'b1;
                    nxt     = ST_RED;
                end
                ST_RED: if (byte_vld) begin
                    take_red = 1'b1;
                    nxt      = ST_GREEN;
                end
                ST_GREEN: if (byte_vld) begin
                    take_green = 1'b1;
                    nxt        = ST_BLUE;
                end
                ST_BLUE: if (byte_vld) begin
                    commit = 1'b1;
                    nxt    = last_pix ? ST_FULL : ST_RED;
                end
                ST_FULL: nxt = ST_FULL;
                default: nxt = ST_RED;
            endcase
        end
    end

    // R7
    restart_to_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHOW && !disp_sw) |=> (state == ST_RED));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld && !disp_sw && state != ST_SHOW) |=> $stable(state));

    // R6
    show_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_sw |=> (state == ST_SHOW));

endmodule

// File: rtl/pxpk_nibble_reg.sv
module pxpk_nibble_reg #(
    parameter int BYTE_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_red,
    input  logic               take_green,
    input  logic [BYTE_W-1:0]  byte_dat,
    output logic [3*NIB_W-1:0] pixel
);

    localparam int TOP = BYTE_W - 1;

    logic [NIB_W-1:0] red_q;
    logic [NIB_W-1:0] grn_q;
    logic [NIB_W-1:0] cur_nib;

    assign cur_nib = byte_dat[TOP -: NIB_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            red_q <= '0;
            grn_q <= '0;
        end else begin
            if (take_red)   red_q <= cur_nib;
            if (take_green) grn_q <= cur_nib;
        end
    end

    assign pixel = {red_q, grn_q, cur_nib};

    // R1
    red_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_green |=> $stable(red_q));

endmodule

// File: rtl/pxpk_addr_gen.sv
module pxpk_addr_gen #(
    parameter int FRAME_PIXELS = 76800,
    parameter int ADDR_W       = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              restart,
    output logic [ADDR_W-1:0] cnt,
    output logic              last_pix,
    output logic              done
);

    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(FRAME_PIXELS - 1);

    assign last_pix = (cnt == LAST_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (restart) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (commit) begin
            if (last_pix) done <= 1'b1;
            else          cnt  <= cnt + 1'b1;
        end
    end

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !last_pix && !restart) |=> (cnt == $past(cnt) + 1'b1));

    // R5
    addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_A);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart) |=> done);

endmodule

// File: rtl/pixel_packer.sv
module pixel_packer
    import pxpk_pkg::*;
#(
    parameter int FRAME_PIXELS = 76800,
    parameter int ADDR_W       = 17,
    parameter int BYTE_W       = 8,
    parameter int NIB_W        = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_vld,
    input  logic [BYTE_W-1:0]  byte_dat,
    input  logic               disp_sw,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [3*NIB_W-1:0] wr_data,
    output logic               frame_done
);

    localparam int PIX_W = 3 * NIB_W;

    pk_state_t         state;
    logic              take_red, take_green, commit, restart, last_pix;
    logic [ADDR_W-1:0] cnt;
    logic [PIX_W-1:0]  pixel;

    pxpk_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .disp_sw    (disp_sw),
        .last_pix   (last_pix),
        .state      (state),
        .take_red   (take_red),
        .take_green (take_green),
        .commit     (commit),
        .restart    (restart)
    );

    pxpk_nibble_reg #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_nib (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_red   (take_red),
        .take_green (take_green),
        .byte_dat   (byte_dat),
        .pixel      (pixel)
    );

    pxpk_addr_gen #(.FRAME_PIXELS(FRAME_PIXELS), .ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .restart  (restart),
        .cnt      (cnt),
        .last_pix (last_pix),
        .done     (frame_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= commit;
            if (commit) begin
                wr_addr <= cnt;
                wr_data <= pixel;
            end
        end
    end

    // R3
    wr_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6
    show_mode_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_sw |=> !wr_en);

    // R5
    no_write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !wr_en);

    // R5
    done_with_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done) |-> (wr_en && wr_addr == ADDR_W'(FRAME_PIXELS - 1)));

endmodule

// File: tb/sim_pixel_packer.sv
module sim_pixel_packer;

    localparam int CLK_PERIOD = 10;
    localparam int NPIX       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_dat = 8'h00;
    logic        disp_sw = 1'b0;
    logic        wr_en;
    logic [16:0] wr_addr;
    logic [11:0] wr_data;
    logic        frame_done;

    int n_cmp = 0;
    int n_bad = 0;
    int n_wr  = 0;
    logic [16:0] last_wa = '0;
    logic [11:0] last_wd = '0;
    bit done_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixel_packer #(.FRAME_PIXELS(NPIX)) u0 (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .disp_sw(disp_sw), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_done(frame_done)
    );

    // behavioural reference model
    int   m_ph, m_addr;
    bit   m_done, m_show;
    logic [3:0]  m_r, m_g;
    logic        e_we;
    logic [16:0] e_addr;
    logic [11:0] e_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_addr = 0; m_done = 0; m_show = 0;
            m_r = 0; m_g = 0; e_we = 0; e_addr = 0; e_data = 0;
        end else begin
            e_we = 0;
            if (disp_sw) m_show = 1;
            else if (m_show) begin
                m_show = 0; m_ph = 0; m_addr = 0; m_done = 0;
            end else if (!m_done && byte_vld) begin
                if (m_ph == 0) begin m_r = byte_dat[7:4]; m_ph = 1; end
                else if (m_ph == 1) begin m_g = byte_dat[7:4]; m_ph = 2; end
                else begin
                    e_we = 1; e_addr = 17'(m_addr);
                    e_data = {m_r, m_g, byte_dat[7:4]};
                    m_ph = 0;
                    if (m_addr == NPIX - 1) m_done = 1;
                    else m_addr = m_addr + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            check(wr_en == e_we, "R3 wr_en", int'(wr_en), int'(e_we));
            check(wr_addr == e_addr, "R4 wr_addr", int'(wr_addr), int'(e_addr));
            check(wr_data == e_data, "R2 wr_data", int'(wr_data), int'(e_data));
            check(frame_done == m_done, "R5 frame_done", int'(frame_done), int'(m_done));
            if (wr_en) begin n_wr++; last_wa = wr_addr; last_wd = wr_data; end
        end
    end

    task automatic send(input logic [7:0] d, input int gap);
        @(negedge clk); byte_vld = 1'b1; byte_dat = d;
        @(negedge clk); byte_vld = 1'b0; byte_dat = 8'h00;
        for (int i = 0; i < gap; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        done_run = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int w0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(wr_en == 0 && wr_addr == 0 && wr_data == 0 && frame_done == 0,
              "R9 reset", {wr_en, wr_data, frame_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 back-to-back bytes
        send(8'hA7, 0); send(8'h5F, 0); send(8'h3C, 0);
        @(negedge clk);
        check(last_wd == 12'hA53, "R1 R2 colour order", int'(last_wd), 'hA53);
        check(last_wa == 0, "R4 first address", int'(last_wa), 0);

        // R10 gaps between bytes
        w0 = n_wr;
        send(8'h1E, 3);
        check(n_wr == w0, "R10 no write in gap", n_wr, w0);
        send(8'hE2, 4); send(8'h79, 2);
        check(last_wd == 12'h1E7 && last_wa == 1, "R10 gapped pixel", int'(last_wd), 'h1E7);

        // R6 R7 partial pixel cut by display mode
        send(8'hFF, 0);
        @(negedge clk); disp_sw = 1'b1;
        w0 = n_wr;
        send(8'h11, 0); send(8'h22, 0); send(8'h33, 0);
        check(n_wr == w0, "R6 ignored in display", n_wr, w0);
        disp_sw = 1'b0;
        @(negedge clk);
        send(8'h40, 0); send(8'h80, 0); send(8'hC0, 0);
        @(negedge clk);
        check(last_wa == 0 && last_wd == 12'h48C, "R7 restart", int'(last_wa), 0);

        // R5 fill the frame, then surplus bytes
        for (int p = 1; p < NPIX; p++) begin
            send(8'(p * 16), 0); send(8'h90, 1); send(8'h0F, 0);
        end
        @(negedge clk);
        check(frame_done == 1 && last_wa == NPIX - 1, "R5 last address", int'(last_wa), NPIX - 1);
        w0 = n_wr;
        send(8'hAA, 0); send(8'hBB, 0); send(8'hCC, 0);
        check(n_wr == w0, "R5 no write after full", n_wr, w0);

        // R8 flag kept through display mode
        disp_sw = 1'b1;
        repeat (5) @(negedge clk);
        check(frame_done == 1, "R8 done held", int'(frame_done), 1);
        disp_sw = 1'b0;
        repeat (2) @(negedge clk);
        check(frame_done == 0, "R7 done cleared", int'(frame_done), 0);
        send(8'h12, 0); send(8'h34, 0); send(8'h56, 0);
        @(negedge clk);
        check(last_wa == 0 && last_wd == 12'h135, "R7 new frame", int'(last_wd), 'h135);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule